// File: doc/BRIEF.md
# Dual-Channel Prioritized Interrupt Controller

This block sits beside a two-channel serial controller. It gathers that controller's event conditions and turns them into one active-low interrupt line for a host processor. Each channel raises three kinds of event: a received character is waiting, the transmit buffer has room, and a line or modem status change has occurred. A pending bit is latched for each of the six events. A fixed priority chain then picks the most urgent enabled one and shows it to the host as a small numeric code. The host acknowledges that event either by writing a register or by pulsing a hardware acknowledge pin. Either way, the pending bit of the source named by the code is cleared.

Software that wants no interrupts at all clears the master enable and reads the per-channel status words instead. These words always show the raw conditions and the pending bits, whatever the enables hold. Each channel also drives a data-request output for an external transfer engine. A separate enable bit in that channel's mode register gates it.

Top module: `sio_irq_ctrl`

## Requirements
- R1: A source's pending bit becomes set at the first clock edge at which its condition input is sampled high after having been low. The enables do not affect this. Source index = channel*3 + kind, where channel A = 0, channel B = 1, and kind receive = 0, transmit = 1, status = 2.
- R2: A pending bit is cleared at any clock edge at which its condition input is sampled low.
- R3: `int_code` shows the highest-priority pending and enabled source as source index + 1. The values run from 1 for A receive to 6 for B status, and the lowest index wins. The value is 0 when no source is both pending and enabled.
- R4: The mode register of a channel is at address 2 for A and address 3 for B. Its bits [0], [1] and [2] enable receive, transmit and status. A pending but disabled source affects neither `int_code` nor `int_n`.
- R5: Bit 3 of the control register (address 0) is the master enable. `int_n` is low exactly when this bit is set and at least one source is both pending and enabled. When the bit is 0, `int_n` stays high.
- R6: `dma_req[ch]` is high exactly when bit 7 of that channel's mode register is set and that channel's receive or transmit condition is high. It is registered one cycle after the inputs.
- R7: A write to address 1 (the data is ignored) or a one-cycle `int_ack` pulse clears the pending bit of the source that `int_code` names. When `int_code` is 0, the acknowledge changes nothing.
- R8: A read returns data one cycle after the address is presented. The reads are:
  - Address 4 (channel A) and address 5 (channel B) return a status word: bits [2:0] hold the raw receive, transmit and status conditions, and bits [5:3] hold their pending bits. This stays valid with every enable cleared.
  - Address 6 returns `int_code` in bits [2:0].
  - Addresses 0, 2 and 3 read back what was written to them.
- R9: After reset, `int_n` is 1, `int_code` is 0 and `dma_req` is 0, and all registers read 0.
- R10: `int_code` and `int_n` are re-evaluated at every clock edge. They reflect a new condition at the second edge after it is first sampled.
- R11: A source that is acknowledged while its condition stays high remains clear until the condition goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_cond | input | 2 | Receive-character-available condition, [0]=A, [1]=B |
| tx_cond | input | 2 | Transmit-buffer-empty condition per channel |
| ext_cond | input | 2 | External/status condition per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | 8 | Write data |
| int_ack | input | 1 | Hardware acknowledge pulse |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| int_n | output | 1 | Active-low interrupt request |
| int_code | output | 3 | Code of the highest-priority enabled pending source |
| dma_req | output | 2 | Per-channel data-request output |

## Verification
The assertions rely on two assumptions about the inputs. First, the condition inputs are synchronous to `clk` and stay steady for at least one cycle. Second, an acknowledge acts on the code currently shown. The stimulus meets both: it changes conditions only at the falling clock edge, and it issues each acknowledge only after the code has settled from the previous change. The one race the pending logic resolves on its own is a fresh rising edge that arrives in the same cycle as an acknowledge naming that source; the rising edge wins. The sweeps cover every combination of six enables against six pending patterns, and every combination of request enable against the per-channel conditions.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NUM_CH     = 2;
  localparam int SRC_PER_CH = 3;
  localparam int NUM_SRC    = NUM_CH * SRC_PER_CH;
  localparam int CODE_W     = $clog2(NUM_SRC + 1);
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;

  localparam int KIND_RX  = 0;
  localparam int KIND_TX  = 1;
  localparam int KIND_EXT = 2;

  localparam int MIE_BIT    = 3;
  localparam int REQ_EN_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_ACK    = 3'd1,
    RA_MODE0  = 3'd2,
    RA_MODE1  = 3'd3,
    RA_STAT0  = 3'd4,
    RA_STAT1  = 3'd5,
    RA_CODE   = 3'd6,
    RA_PEND   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/icu_pend.sv
module icu_pend (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic clr,
  output logic pend
);
  logic cond_q;
  logic rise;

  assign rise = cond & ~cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      cond_q <= cond;
      pend   <= rise | (pend & cond & ~clr);
    end
  end

  // R1: a new rising condition always lands in the pending bit
  p_rise_sets_r1: assert property (@(posedge clk) disable iff (rst)
    (cond && !cond_q) |=> pend);
  // R2: a low condition empties the bit
  p_low_clears_r2: assert property (@(posedge clk) disable iff (rst)
    !cond |=> !pend);
  // R11: acknowledged without a fresh edge, the bit stays empty
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (clr && cond_q) |=> !pend);
endmodule

// File: rtl/icu_prio.sv
module icu_prio
  import sio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  input  logic               mie,
  input  logic               ack,
  output logic [CODE_W-1:0]  code,
  output logic               int_n,
  output logic [NUM_SRC-1:0] clr
);
  logic [NUM_SRC-1:0] active;
  logic [CODE_W-1:0]  code_nxt;

  assign active = pend & en;

  always_comb begin
    code_nxt = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) code_nxt = CODE_W'(i + 1);
    end
  end

  always_comb begin
    clr = '0;
    if (ack && code != '0) clr[int'(code) - 1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      int_n <= 1'b1;
    end else begin
      code  <= code_nxt;
      int_n <= ~(mie & (|active));
    end
  end

  // R5: master enable off keeps the line released
  p_mie_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !mie |=> int_n);
  // R5: an asserted line always comes with a nonzero code
  p_line_has_code_r5: assert property (@(posedge clk) disable iff (rst)
    !int_n |-> (code != '0));
  // R3: code never names a source outside the six
  p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
    code <= CODE_W'(NUM_SRC));
  // R7: an acknowledge clears at most one source
  p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr));
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import sio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] cond,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [CODE_W-1:0]  code,
  output logic               mie,
  output logic [NUM_SRC-1:0] src_en,
  output logic [NUM_CH-1:0]  req_en,
  output logic               sw_ack,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] mode_q [NUM_CH];

  assign mie    = ctrl_q[MIE_BIT];
  assign sw_ack = wr && (addr == RA_ACK);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr && addr == RA_CTRL) ctrl_q <= wdata;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mode
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(int'(RA_MODE0) + ch);
    always_ff @(posedge clk) begin
      if (rst) mode_q[ch] <= '0;
      else if (wr && addr == MODE_ADDR) mode_q[ch] <= wdata;
    end
    assign src_en[ch*SRC_PER_CH +: SRC_PER_CH] = mode_q[ch][SRC_PER_CH-1:0];
    assign req_en[ch] = mode_q[ch][REQ_EN_BIT];
  end

  function automatic logic [DATA_W-1:0] stat_word(input int ch);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SRC_PER_CH-1:0]            = cond[ch*SRC_PER_CH +: SRC_PER_CH];
    w[2*SRC_PER_CH-1:SRC_PER_CH] = pend[ch*SRC_PER_CH +: SRC_PER_CH];
    return w;
  endfunction

  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    case (reg_addr_e'(addr))
      RA_CTRL:  rd_nxt = ctrl_q;
      RA_MODE0: rd_nxt = mode_q[0];
      RA_MODE1: rd_nxt = mode_q[1];
      RA_STAT0: rd_nxt = stat_word(0);
      RA_STAT1: rd_nxt = stat_word(1);
      RA_CODE:  rd_nxt[CODE_W-1:0] = code;
      RA_PEND:  rd_nxt[NUM_SRC-1:0] = pend;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end

  // R7: an acknowledge write stores nothing
  p_ack_no_store_r7: assert property (@(posedge clk) disable iff (rst)
    sw_ack |=> ($stable(ctrl_q) && $stable(mode_q[0]) && $stable(mode_q[1])));
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rx_cond,
  input  logic [NUM_CH-1:0] tx_cond,
  input  logic [NUM_CH-1:0] ext_cond,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              int_ack,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              int_n,
  output logic [CODE_W-1:0] int_code,
  output logic [NUM_CH-1:0] dma_req
);
  logic [NUM_SRC-1:0] cond;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_CH-1:0]  req_en;
  logic               mie;
  logic               sw_ack;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign cond[ch*SRC_PER_CH + KIND_RX]  = rx_cond[ch];
    assign cond[ch*SRC_PER_CH + KIND_TX]  = tx_cond[ch];
    assign cond[ch*SRC_PER_CH + KIND_EXT] = ext_cond[ch];

    always_ff @(posedge clk) begin
      if (rst) dma_req[ch] <= 1'b0;
      else     dma_req[ch] <= req_en[ch] & (rx_cond[ch] | tx_cond[ch]);
    end

    // R6: a cleared request enable holds the request low
    p_req_gate_r6: assert property (@(posedge clk) disable iff (rst)
      !req_en[ch] |=> !dma_req[ch]);
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    icu_pend u_pend (
      .clk  (clk),
      .rst  (rst),
      .cond (cond[s]),
      .clr  (clr[s]),
      .pend (pend[s])
    );
  end

  icu_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .cond   (cond),
    .pend   (pend),
    .code   (int_code),
    .mie    (mie),
    .src_en (src_en),
    .req_en (req_en),
    .sw_ack (sw_ack),
    .rdata  (reg_rdata)
  );

  icu_prio u_prio (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend),
    .en    (src_en),
    .mie   (mie),
    .ack   (sw_ack | int_ack),
    .code  (int_code),
    .int_n (int_n),
    .clr   (clr)
  );
endmodule

// File: tb/sio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module sio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rx_cond = '0, tx_cond = '0, ext_cond = '0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       int_ack = 1'b0;
  logic [7:0] reg_rdata;
  logic       int_n;
  logic [2:0] int_code;
  logic [1:0] dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .rx_cond(rx_cond), .tx_cond(tx_cond),
    .ext_cond(ext_cond), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .int_ack(int_ack), .reg_rdata(reg_rdata),
    .int_n(int_n), .int_code(int_code), .dma_req(dma_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    step(1);
    d = reg_rdata;
  endtask

  // pattern bit i is source i: A rx, A tx, A ext, B rx, B tx, B ext
  task automatic set_conds(input logic [5:0] p);
    rx_cond  = {p[3], p[0]};
    tx_cond  = {p[4], p[1]};
    ext_cond = {p[5], p[2]};
  endtask

  function automatic int exp_code(input logic [5:0] act);
    for (int i = 0; i < 6; i++) if (act[i]) return i + 1;
    return 0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    step(4);
    rst = 1'b0;
    step(1);

    // R9: reset state
    check("R9 int_n", int_n, 1);
    check("R9 int_code", int_code, 0);
    check("R9 dma_req", dma_req, 0);
    rd(3'd0, d); check("R9 ctrl", d, 0);
    rd(3'd2, d); check("R9 modeA", d, 0);
    rd(3'd5, d); check("R9 statB", d, 0);

    // R8: polled status with everything disabled
    set_conds(6'b101101);
    step(1);
    rd(3'd4, d); check("R8 statA", d, 8'b00_101_101);
    rd(3'd5, d); check("R8 statB", d, 8'b00_101_101);
    rd(3'd6, d); check("R8 code read, R4 disabled", d, 0);
    check("R5 no line when disabled", int_n, 1);
    set_conds(6'b000011);
    step(1);
    rd(3'd4, d); check("R2 statA after drop", d, 8'b00_011_011);
    rd(3'd5, d); check("R2 statB after drop", d, 0);

    // R3, R4, R10: sweep of enables against pending patterns
    wr(3'd0, 8'h08);
    for (int e = 0; e < 64; e++) begin
      for (int p = 0; p < 64; p++) begin
        set_conds(6'b0);
        wr(3'd2, {5'b0, e[2:0]});
        wr(3'd3, {5'b0, e[5:3]});
        set_conds(p[5:0]);
        step(1);
        if (e == 63) check("R10 code not yet updated", int_code, 0);
        step(1);
        check("R3 R4 code", int_code, exp_code(p[5:0] & e[5:0]));
        check("R5 line", int_n, ((p[5:0] & e[5:0]) != 0) ? 0 : 1);
      end
    end

    // R5: master enable off then on
    set_conds(6'b0);
    wr(3'd0, 8'hF7);
    wr(3'd2, 8'h07);
    wr(3'd3, 8'h07);
    set_conds(6'h3F);
    step(3);
    check("R5 line off with mie=0", int_n, 1);
    check("R3 code still shown", int_code, 1);
    rd(3'd0, d); check("R8 ctrl readback", d, 8'hF7);
    wr(3'd0, 8'h08);
    step(1);
    check("R5 line on with mie=1", int_n, 0);

    // R7: software acknowledge walks the priority chain
    for (int k = 1; k <= 6; k++) begin
      check("R7 code before ack", int_code, k);
      wr(3'd1, 8'hA5);
      step(1);
    end
    check("R7 code after all acks", int_code, 0);
    check("R7 line after all acks", int_n, 1);
    rd(3'd0, d); check("R7 ack write stores nothing", d, 8'h08);

    // R11: conditions still high, nothing re-pends
    step(3);
    rd(3'd7, d); check("R11 no re-pend while high", d, 0);
    set_conds(6'b111101);
    step(1);
    set_conds(6'h3F);
    step(2);
    check("R11 re-pend after new edge", int_code, 2);

    // R7: hardware acknowledge pulse
    int_ack = 1'b1;
    step(1);
    int_ack = 1'b0;
    step(1);
    check("R7 hw ack clears", int_code, 0);

    // R7: acknowledge with code 0 changes nothing
    set_conds(6'b0);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    set_conds(6'h3F);
    step(2);
    wr(3'd1, 8'h00);
    rd(3'd7, d); check("R7 ack with code 0 keeps pending", d, 8'h3F);
    wr(3'd3, 8'h07);
    step(1);
    check("R7 pending survived idle ack", int_code, 4);

    // R6: request enable against per-channel conditions
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        set_conds(6'b0);
        wr(3'd2, {m[0], 7'b0});
        wr(3'd3, {m[1], 7'b0});
        rx_cond = {1'b0, c[0]};
        tx_cond = {c[1], 1'b0};
        step(1);
        check("R6 dma_req", dma_req, m[1:0] & c[1:0]);
      end
    end
    rd(3'd3, d); check("R8 modeB readback", d, 8'h80);

    finish_run();
  end
endmodule